// File: doc/BRIEF.md
# Pipelined Read Request Issuer

This block is the request side of a graphics bus master on a shared AGP/PCI address/data bus. It accepts read commands from the rendering logic: a byte address, a byte count and a priority flag, through a valid/ready handshake. It asks the bridge for the bus and waits for a start grant. It then places one read request on the bus on each clock of a burst, with the pipe strobe held low. Each request packs a quadword address, a length code and a command code into a single cycle. Reads over 64 bytes are cut into 32-byte pieces.

The block keeps a count of reads that have been enqueued but not yet answered. A one-cycle completion pulse from the reply side retires one read. A burst ends early when the count is about to reach its limit. The rest of the command then waits for credit and is issued in a later burst. On the final request of every burst the block raises its bus request while the pipe strobe is still low, so the arbiter knows the burst is over.

Top module: `rdpipe_issuer`

## Requirements
- R1: `cmdReady` is high only while the block is idle, with no pipe strobe and no bus request. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. While a command still has pieces left, `cmdReady` stays low.
- R2: When work is pending and fewer than 4 reads are outstanding, `busReqN` is driven low in the cycle after the command is taken.
- R3: A start grant is `busGntN` low together with `busStatus` equal to 3'b111. In the clock after the start grant, the block drives the first request with `pipeN` low. With any other status value it enqueues nothing.
- R4: In every cycle with `pipeN` low, `adOe` is high. In that cycle `adOut[31:3]` holds the quadword address, `adOut[2:0]` holds the length code, and `cbeN` holds the command. In all other cycles `adOe` is low, `adOut` is zero and `cbeN` is 4'hF.
- R5: The last request of a burst is driven with `busReqN` high and `pipeN` low. On the next clock `pipeN` is high and `adOe` is low.
- R6: Once the first request is on the bus, the rest of the burst is issued back to back even if `busGntN` has returned high.
- R7: The quadword count is ceil(bytes/8), taken from the address rounded down to 8 bytes; a byte count of zero counts as one quadword. A request of n quadwords carries length code n-1. A command of 64 bytes or fewer becomes one request. A larger command becomes 4-quadword pieces (code 3'b011) at addresses 32 bytes apart, followed by a final piece that carries the remainder.
- R8: `cbeN` carries 4'b0100 for a high-priority command and 4'b0000 for a low-priority one.
- R9: `outstanding` goes up by one on each enqueue cycle and down by one on each `doneStrobe` pulse. When both occur in the same cycle it is unchanged, and it never exceeds 4.
- R10: No request is enqueued while 4 reads are outstanding. A burst whose enqueue brings the count to 4 ends on that request. `busReqN` then stays high until a completion frees credit, and it goes low in the cycle after that completion.
- R11: While `rstN` is low, `busReqN` and `pipeN` are high and `outstanding` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Read command offered |
| cmdReady | output | 1 | Block is idle and takes a command |
| cmdAddr | input | 32 | Byte address of the read |
| cmdBytes | input | BYTES_W | Byte count of the read |
| cmdHiPri | input | 1 | Request high-priority command code |
| doneStrobe | input | 1 | One-cycle pulse: one outstanding read answered |
| busReqN | output | 1 | Active-low bus request |
| busGntN | input | 1 | Active-low bus grant |
| busStatus | input | 3 | Bus status code from the arbiter |
| pipeN | output | 1 | Active-low pipe strobe, one request per low cycle |
| adOut | output | 32 | Address and length of the current request |
| adOe | output | 1 | Drive enable for `adOut` and `cbeN` |
| cbeN | output | 4 | Command code of the current request |
| outstanding | output | CNT_W | Reads enqueued and not yet answered |

## Verification
A start grant seen at one rising edge puts the first request on the bus after that same edge, so it is visible one cycle later. An enqueue or a completion changes `outstanding` one edge after the cycle it occupies. A burst-ending request releases `pipeN` and the drivers one edge later. A completion that frees credit pulls `busReqN` low in the cycle right after its edge. Every stimulus is driven and every output sampled on the falling clock edge, so each expected value is compared exactly one edge after the cycle that causes it. A bench arbiter model grants at one falling edge and withdraws the grant at the next falling edge where it sees the pipe strobe. This lets the full piece sequence of each table entry be recorded and compared against values computed from R7 and R8.

// File: rtl/rdpipe_pkg.sv
package rdpipe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARB   = 2'd1,
    ST_ISSUE = 2'd2
  } seqState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;      // capture a new command
    logic advance;   // step to the next piece
    logic enqueue;   // current piece is on the bus this cycle
  } dpStrobe_t;

  localparam logic [3:0] CMD_RD_LO    = 4'b0000;
  localparam logic [3:0] CMD_RD_HI    = 4'b0100;
  localparam logic [3:0] CBE_IDLE     = 4'hF;
  localparam logic [2:0] STATUS_START = 3'b111;

endpackage

// File: rtl/rdpipe_ctrl.sv
module rdpipe_ctrl
  import rdpipe_pkg::*;
#(
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic             doneStrobe,
  input  logic             busGntN,
  input  logic [2:0]       busStatus,
  input  logic             lastPiece,
  output dpStrobe_t        strobe,
  output logic             busReqN,
  output logic             pipeN,
  output logic [CNT_W-1:0] outstanding
);

  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(MAX_OUT);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(MAX_OUT - 1);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] count;
  logic credit, startSeen, burstEnd, retire;

  assign credit    = (count < LIMIT);
  assign startSeen = !busGntN && (busStatus == STATUS_START);
  // stop the burst on the piece that fills the last credit slot
  assign burstEnd  = lastPiece || (count == LIMIT_M1);
  assign retire    = doneStrobe && ((count != '0) || strobe.enqueue);

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    cmdReady       = 1'b0;
    busReqN        = 1'b1;
    pipeN          = 1'b1;
    case (state)
      ST_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strobe.load = 1'b1;
          stateNext   = ST_ARB;
        end
      end
      ST_ARB: begin
        busReqN = !credit;
        if (credit && startSeen) stateNext = ST_ISSUE;
      end
      ST_ISSUE: begin
        pipeN          = 1'b0;
        busReqN        = burstEnd;
        strobe.enqueue = 1'b1;
        strobe.advance = 1'b1;
        if (burstEnd) stateNext = lastPiece ? ST_IDLE : ST_ARB;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      count <= '0;
    end else begin
      state <= stateNext;
      case ({strobe.enqueue, retire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign outstanding = count;

endmodule

// File: rtl/rdpipe_dp.sv
module rdpipe_dp
  import rdpipe_pkg::*;
#(
  parameter int BYTES_W     = 12,
  parameter int PIECE_QW    = 4,
  parameter int SPLIT_BYTES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [31:3]        cmdQwAddr,
  input  logic [BYTES_W-1:0] cmdBytes,
  input  logic               cmdHiPri,
  output logic               lastPiece,
  output logic [31:0]        adOut,
  output logic               adOe,
  output logic [3:0]         cbeN
);

  localparam int QW_W = BYTES_W - 2;
  localparam logic [QW_W-1:0] PIECE = QW_W'(PIECE_QW);

  logic [28:0]     qwAddr;
  logic [QW_W-1:0] qwLeft, pieceQw, qwLoad;
  logic [BYTES_W:0] roundUp;
  logic            split, hiPri;
  logic [2:0]      lenCode;

  assign roundUp = {1'b0, cmdBytes} + (BYTES_W+1)'(7);
  assign qwLoad  = (cmdBytes == '0) ? QW_W'(1) : roundUp[BYTES_W:3];

  assign pieceQw   = (split && (qwLeft > PIECE)) ? PIECE : qwLeft;
  assign lenCode   = 3'(pieceQw - 1'b1);
  assign lastPiece = (qwLeft == pieceQw);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qwAddr <= '0;
      qwLeft <= '0;
      split  <= 1'b0;
      hiPri  <= 1'b0;
    end else if (strobe.load) begin
      qwAddr <= cmdQwAddr;
      qwLeft <= qwLoad;
      split  <= (cmdBytes > BYTES_W'(SPLIT_BYTES));
      hiPri  <= cmdHiPri;
    end else if (strobe.advance) begin
      qwAddr <= qwAddr + 29'(pieceQw);
      qwLeft <= qwLeft - pieceQw;
    end
  end

  assign adOe  = strobe.enqueue;
  assign adOut = strobe.enqueue ? {qwAddr, lenCode} : 32'd0;
  assign cbeN  = !strobe.enqueue ? CBE_IDLE : (hiPri ? CMD_RD_HI : CMD_RD_LO);

endmodule

// File: rtl/rdpipe_issuer.sv
module rdpipe_issuer
  import rdpipe_pkg::*;
#(
  parameter int BYTES_W     = 12,
  parameter int MAX_OUT     = 4,
  parameter int PIECE_QW    = 4,
  parameter int SPLIT_BYTES = 64,
  localparam int CNT_W      = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [31:0]        cmdAddr,
  input  logic [BYTES_W-1:0] cmdBytes,
  input  logic               cmdHiPri,
  input  logic               doneStrobe,
  output logic               busReqN,
  input  logic               busGntN,
  input  logic [2:0]         busStatus,
  output logic               pipeN,
  output logic [31:0]        adOut,
  output logic               adOe,
  output logic [3:0]         cbeN,
  output logic [CNT_W-1:0]   outstanding
);

  dpStrobe_t strobe;
  logic      lastPiece;
  logic      unusedAddrBits;

  assign unusedAddrBits = ^cmdAddr[2:0];

  rdpipe_ctrl #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .doneStrobe(doneStrobe), .busGntN(busGntN), .busStatus(busStatus),
    .lastPiece(lastPiece), .strobe(strobe), .busReqN(busReqN),
    .pipeN(pipeN), .outstanding(outstanding)
  );

  rdpipe_dp #(.BYTES_W(BYTES_W), .PIECE_QW(PIECE_QW), .SPLIT_BYTES(SPLIT_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdQwAddr(cmdAddr[31:3]),
    .cmdBytes(cmdBytes), .cmdHiPri(cmdHiPri), .lastPiece(lastPiece),
    .adOut(adOut), .adOe(adOe), .cbeN(cbeN)
  );

endmodule

// File: rtl/rdpipe_chk.sv
module rdpipe_chk #(
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdReady,
  input logic             doneStrobe,
  input logic             busReqN,
  input logic             busGntN,
  input logic [2:0]       busStatus,
  input logic             pipeN,
  input logic             adOe,
  input logic [CNT_W-1:0] outstanding
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (pipeN && busReqN));

  p_start_to_pipe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pipeN && !busReqN && !busGntN && busStatus == 3'b111) |=> !pipeN);

  p_burst_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeN && busReqN) |=> (pipeN && !adOe));

  p_count_up_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeN && !doneStrobe) |=> (outstanding == CNT_W'($past(outstanding) + 1'b1)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= CNT_W'(MAX_OUT));

  p_credit_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeN || !busReqN) |-> (outstanding < CNT_W'(MAX_OUT)));

  p_reset_state_r11: assert property (@(posedge clk)
    !rstN |-> (busReqN && pipeN && outstanding == '0));

endmodule

bind rdpipe_issuer rdpipe_chk #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .doneStrobe(doneStrobe),
  .busReqN(busReqN), .busGntN(busGntN), .busStatus(busStatus),
  .pipeN(pipeN), .adOe(adOe), .outstanding(outstanding)
);

// File: tb/sim_rdpipe_issuer.sv
module sim_rdpipe_issuer;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  typedef struct packed {
    logic [31:0] addr;
    logic [11:0] bytes;
    logic        hi;
    logic [7:0]  nPieces;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 12'd8,   1'b0, 8'd1},
    '{32'h0000_2008, 12'd64,  1'b1, 8'd1},
    '{32'h0000_3000, 12'd65,  1'b0, 8'd3},
    '{32'h0000_4004, 12'd20,  1'b0, 8'd1},
    '{32'h0000_5000, 12'd200, 1'b1, 8'd7},
    '{32'h0000_6000, 12'd0,   1'b0, 8'd1}
  };

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdHiPri = 0, doneStrobe = 0;
  logic [31:0] cmdAddr = 0;
  logic [11:0] cmdBytes = 0;
  logic busGntN = 1;
  logic [2:0] busStatus = 0;
  logic cmdReady, busReqN, pipeN, adOe;
  logic [31:0] adOut;
  logic [3:0] cbeN;
  logic [2:0] outstanding;

  int total = 0, fails = 0;
  bit arbAuto = 0, autoDone = 0, overflow = 0, finished = 0;
  logic [31:0] recAd [0:63];
  logic [3:0]  recCbe [0:63];
  logic        recReq [0:63];
  int recN = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdpipe_issuer u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdBytes(cmdBytes), .cmdHiPri(cmdHiPri),
    .doneStrobe(doneStrobe), .busReqN(busReqN), .busGntN(busGntN),
    .busStatus(busStatus), .pipeN(pipeN), .adOut(adOut), .adOe(adOe),
    .cbeN(cbeN), .outstanding(outstanding)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // arbiter model: grant on request, withdraw once the pipe strobe shows
  initial forever begin
    @(negedge clk);
    if (arbAuto) begin
      if (!busGntN) begin
        if (!pipeN || busReqN) begin busGntN = 1; busStatus = 0; end
      end else if (!busReqN && pipeN) begin
        busGntN = 0; busStatus = 3'b111;
      end
    end
  end

  // completion model
  initial begin
    int tick = 0;
    forever begin
      @(negedge clk);
      if (autoDone) begin
        tick++;
        doneStrobe = (tick % 3 == 0) && (outstanding != 0);
      end
    end
  end

  // monitor of enqueued requests
  initial forever begin
    @(negedge clk);
    if (outstanding > 3'd4) overflow = 1;
    if (rstN && !pipeN && recN < 64) begin
      recAd[recN] = adOut; recCbe[recN] = cbeN; recReq[recN] = busReqN;
      recN++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic sendCmd(input logic [31:0] a, input logic [11:0] b, input logic h);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1; cmdAddr = a; cmdBytes = b; cmdHiPri = h;
    @(negedge clk);
    cmdValid = 0;
  endtask

  initial begin
    // reset state (R11, R1)
    repeat (3) @(negedge clk);
    check(busReqN && pipeN && outstanding == 0, "R11", "reset outputs",
          {busReqN, pipeN, outstanding}, 5'b11000);
    check(!adOe && cbeN == 4'hF && adOut == 0, "R4", "released drivers",
          {adOe, cbeN}, 5'h0F);
    rstN = 1;
    @(negedge clk);
    check(cmdReady == 1, "R1", "ready when idle", cmdReady, 1);

    // directed: grant handling, split, simultaneous count change
    sendCmd(32'h0000_8000, 12'd96, 1'b1);
    check(busReqN == 0 && pipeN == 1, "R2", "request after accept", busReqN, 0);
    check(cmdReady == 0, "R1", "busy not ready", cmdReady, 0);
    busGntN = 0; busStatus = 3'b110;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(pipeN == 1, "R3", "non-start status ignored", pipeN, 1);
    end
    busStatus = 3'b111;
    @(negedge clk);
    check(pipeN == 0, "R3", "first request after start", pipeN, 0);
    check(adOe && adOut == {29'(32'h8000 >> 3), 3'd3}, "R4", "piece0 ad", adOut,
          {29'(32'h8000 >> 3), 3'd3});
    check(cbeN == 4'b0100, "R8", "high priority code", cbeN, 4'b0100);
    busGntN = 1; busStatus = 0;
    @(negedge clk);
    check(pipeN == 0 && adOut == {29'(32'h8020 >> 3), 3'd3}, "R6", "piece1 without grant",
          adOut, {29'(32'h8020 >> 3), 3'd3});
    check(outstanding == 1, "R9", "count after one enqueue", outstanding, 1);
    doneStrobe = 1;
    @(negedge clk);
    doneStrobe = 0;
    check(pipeN == 0 && busReqN == 1, "R5", "last piece drops request", busReqN, 1);
    check(adOut == {29'(32'h8040 >> 3), 3'd3}, "R7", "piece2 address", adOut,
          {29'(32'h8040 >> 3), 3'd3});
    check(outstanding == 1, "R9", "enqueue with completion", outstanding, 1);
    @(negedge clk);
    check(pipeN == 1 && adOe == 0, "R5", "release after last", {pipeN, adOe}, 2'b10);
    check(outstanding == 2, "R9", "count after burst", outstanding, 2);

    // directed: credit limit (R10)
    sendCmd(32'h0000_9000, 12'd96, 1'b0);
    busGntN = 0; busStatus = 3'b111;
    @(negedge clk);
    check(pipeN == 0 && busReqN == 0, "R10", "first piece under credit", busReqN, 0);
    check(cbeN == 4'b0000, "R8", "low priority code", cbeN, 0);
    busGntN = 1; busStatus = 0;
    @(negedge clk);
    check(pipeN == 0 && busReqN == 1, "R10", "burst ends at limit", busReqN, 1);
    @(negedge clk);
    check(outstanding == 4, "R9", "count at limit", outstanding, 4);
    for (int k = 0; k < 3; k++) begin
      check(pipeN && busReqN && !cmdReady, "R10", "stall without credit",
            {pipeN, busReqN, cmdReady}, 3'b110);
      @(negedge clk);
    end
    doneStrobe = 1;
    @(negedge clk);
    doneStrobe = 0;
    check(busReqN == 0 && outstanding == 3, "R10", "re-request after completion",
          {busReqN, outstanding}, 4'b0011);
    recN = 0;
    arbAuto = 1; autoDone = 1;
    while (!cmdReady || outstanding != 0) @(negedge clk);
    check(recN == 1 && recAd[0] == {29'(32'h9040 >> 3), 3'd3}, "R10", "remaining piece",
          recAd[0], {29'(32'h9040 >> 3), 3'd3});

    // table walk
    for (int i = 0; i < NV; i++) begin
      int qw, left, pq, na;
      bit split;
      recN = 0;
      sendCmd(VECS[i].addr, VECS[i].bytes, VECS[i].hi);
      while (!cmdReady || outstanding != 0) @(negedge clk);
      check(recN == int'(VECS[i].nPieces), "R7", $sformatf("vec%0d piece count", i),
            recN, VECS[i].nPieces);
      qw = (VECS[i].bytes == 0) ? 1 : (int'(VECS[i].bytes) + 7) / 8;
      split = VECS[i].bytes > 64;
      left = qw;
      na = int'(VECS[i].addr >> 3);
      for (int k = 0; k < recN && left > 0; k++) begin
        logic [31:0] expAd;
        pq = (split && left > 4) ? 4 : left;
        expAd = {29'(na), 3'(pq - 1)};
        check(recAd[k] == expAd, "R7", $sformatf("vec%0d piece%0d ad", i, k), recAd[k], expAd);
        check(recCbe[k] == (VECS[i].hi ? 4'b0100 : 4'b0000), "R8",
              $sformatf("vec%0d piece%0d cmd", i, k), recCbe[k], VECS[i].hi ? 4 : 0);
        na += pq; left -= pq;
      end
      if (recN > 0)
        check(recReq[recN-1] == 1, "R5", $sformatf("vec%0d final marks end", i),
              recReq[recN-1], 1);
    end
    check(!overflow, "R9", "count never above limit", overflow, 0);
    report();
  end

endmodule